// File: doc/BRIEF.md
# Clock Domain Gating Manager

This block decides when the clocks of one clock domain may be stopped and when they must run again. The domain feeds a parameterized number of modules. Each module is marked at build time as either an initiator, which announces that it has nothing more to issue by raising a standby line, or a target, which is asked to go quiet through an idle request and answers with an acknowledge. When software allows automatic gating and every initiator is in standby, the manager raises the idle request to all targets and waits. Once every target acknowledges, it gates the interface clocks of the whole domain at once. Any reason to stay awake that appears during that wait cancels it.

Functional clocks come in three kinds, fixed by parameter masks. A mandatory clock runs whenever the domain is not gated. An optional clock runs only when its software enable bit is set. A permanent clock never stops. On wake-up, the manager turns the clocks back on first. It then withdraws the idle request, and it reports the domain as active only after every target has dropped its acknowledge. All enables come straight from flip-flops, so they can drive latch-based clock gates without glitches.

Top module: `clkdom_gate_mgr`

## Requirements
- R1: `dom_state` always holds one of three codes: 2'b00 = active, 2'b01 = idle transition, 2'b10 = inactive. It never holds 2'b11.
- R2: From active, the domain enters idle transition on the next clock edge when all of these hold: `auto_gate_en` is 1, every initiator's `mst_standby` bit is 1, `wake_req` is 0, and `sw_fclk_en` equals its value on the previous edge. Active never goes straight to inactive.
- R3: From idle transition, the domain enters inactive only on an edge where every target's `slv_idle_ack` bit is 1 and no abort cause from R4 is present. Until then it stays in idle transition.
- R4: In idle transition, any of the following sends the domain back to active on the next edge and withdraws the idle request: `wake_req` = 1, a change of `sw_fclk_en`, any initiator's standby = 0, or `auto_gate_en` = 0. An abort wins over completion when both fall in the same cycle.
- R5: The bits of `iclk_en` always equal each other. They are 0 only while the domain is gated and 1 otherwise, including the whole wake-up sequence.
- R6: A mandatory functional clock (a 0 in both `FCLK_OPT` and `FCLK_PERM`) is enabled whenever the domain is not gated, whatever its software bit says.
- R7: An optional functional clock (bit set in `FCLK_OPT`) is enabled one edge after its `sw_fclk_en` bit is sampled as 1, provided the domain is not gated. It is off while gated.
- R8: A permanent functional clock (bit set in `FCLK_PERM`) is enabled at all times.
- R9: `slv_idle_req` is 1 on every target bit, and 0 on every initiator bit, from entry into idle transition until one edge after wake-up starts. It is 0 on all bits otherwise.
- R10: While gated, any cause listed in R4 starts wake-up. On the first edge, the clocks turn on, the idle request stays up and the state stays inactive. On the next edge, the idle request drops. The state becomes active on the first edge after that at which no target acknowledges.
- R11: Synchronous reset gives: state active, all `iclk_en` bits 1, `slv_idle_req` 0, and `fclk_en` = mandatory plus permanent clocks on, optional clocks off.
- R12: The `slv_idle_ack` bits of initiators and the `mst_standby` bits of targets have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of the manager |
| rst | input | 1 | Synchronous active-high reset |
| wake_req | input | 1 | Wake-up request for the domain |
| auto_gate_en | input | 1 | Software permission for automatic gating |
| sw_fclk_en | input | N_FCLK | Software enable bits for the functional clocks |
| mst_standby | input | N_MOD | Standby indication, used on initiator bits only |
| slv_idle_ack | input | N_MOD | Idle acknowledge, used on target bits only |
| slv_idle_req | output | N_MOD | Idle request to the targets |
| iclk_en | output | N_MOD | Interface clock gate enables, one per module |
| fclk_en | output | N_FCLK | Functional clock gate enables |
| dom_state | output | 2 | Domain state code (see R1) |

## Verification
Two events can land on the same edge: the last target acknowledge that would complete the idle transition, and an abort cause (a wake request, an initiator leaving standby, or a software enable change). The bench provokes this coincidence directly, by raising the final acknowledge and dropping an initiator's standby together. Random stimulus also produces it many times over. The outcome is judged against a cycle-level reference model built from R3 and R4. The expected result is a return to active with the idle request withdrawn and the interface clocks never gated.

// File: rtl/cgm_pkg.sv
package cgm_pkg;

    typedef enum logic [1:0] {
        DOM_ACTIVE     = 2'b00,
        DOM_IDLE_TRANS = 2'b01,
        DOM_INACTIVE   = 2'b10
    } dom_state_e;

    typedef enum logic [2:0] {
        PH_RUN,
        PH_IDLEREQ,
        PH_GATED,
        PH_WAKE_CLK,
        PH_WAKE_ACK
    } phase_e;

    typedef struct packed {
        logic all_standby;
        logic all_ack;
        logic no_ack;
    } hs_sum_t;

    function automatic dom_state_e phase_to_dom(phase_e p);
        case (p)
            PH_RUN:     return DOM_ACTIVE;
            PH_IDLEREQ: return DOM_IDLE_TRANS;
            default:    return DOM_INACTIVE;
        endcase
    endfunction

    function automatic logic phase_clocks_on(phase_e p);
        return p != PH_GATED;
    endfunction

    function automatic logic phase_req_on(phase_e p);
        return (p == PH_IDLEREQ) || (p == PH_GATED) || (p == PH_WAKE_CLK);
    endfunction

endpackage

// File: rtl/cgm_hs_agg.sv
module cgm_hs_agg #(
    parameter int unsigned N_MOD = 4,
    parameter logic [N_MOD-1:0] IS_MASTER = 4'b0011
) (
    input  logic [N_MOD-1:0] mst_standby,
    input  logic [N_MOD-1:0] slv_idle_ack,
    output cgm_pkg::hs_sum_t hs
);
    logic [N_MOD-1:0] stby_ok;
    logic [N_MOD-1:0] ack_hi;
    logic [N_MOD-1:0] ack_lo;

    for (genvar i = 0; i < N_MOD; i++) begin : g_mod
        if (IS_MASTER[i]) begin : g_init
            assign stby_ok[i] = mst_standby[i];
            assign ack_hi[i]  = 1'b1;
            assign ack_lo[i]  = 1'b1;
        end else begin : g_tgt
            assign stby_ok[i] = 1'b1;
            assign ack_hi[i]  = slv_idle_ack[i];
            assign ack_lo[i]  = ~slv_idle_ack[i];
        end
    end

    assign hs.all_standby = &stby_ok;
    assign hs.all_ack     = &ack_hi;
    assign hs.no_ack      = &ack_lo;
endmodule

// File: rtl/cgm_phase_fsm.sv
module cgm_phase_fsm
    import cgm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  hs_sum_t hs,
    input  logic    wake_req,
    input  logic    auto_gate_en,
    input  logic    sw_chg,
    output phase_e  phase_nxt
);
    phase_e phase_q;
    logic   stay_awake;

    assign stay_awake = wake_req | sw_chg | ~hs.all_standby | ~auto_gate_en;

    always_comb begin
        phase_nxt = phase_q;
        case (phase_q)
            PH_RUN:      if (!stay_awake) phase_nxt = PH_IDLEREQ;
            PH_IDLEREQ:  if (stay_awake) phase_nxt = PH_RUN;
                         else if (hs.all_ack) phase_nxt = PH_GATED;
            PH_GATED:    if (stay_awake) phase_nxt = PH_WAKE_CLK;
            PH_WAKE_CLK: phase_nxt = PH_WAKE_ACK;
            PH_WAKE_ACK: if (hs.no_ack) phase_nxt = PH_RUN;
            default:     phase_nxt = PH_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_RUN;
        else     phase_q <= phase_nxt;
    end
endmodule

// File: rtl/cgm_enable_regs.sv
module cgm_enable_regs
    import cgm_pkg::*;
#(
    parameter int unsigned N_MOD  = 4,
    parameter int unsigned N_FCLK = 4,
    parameter logic [N_MOD-1:0]  IS_MASTER = 4'b0011,
    parameter logic [N_FCLK-1:0] FCLK_OPT  = 4'b0110,
    parameter logic [N_FCLK-1:0] FCLK_PERM = 4'b1000
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_nxt,
    input  logic [N_FCLK-1:0] sw_fclk_en,
    output logic              sw_chg,
    output logic [N_MOD-1:0]  iclk_en,
    output logic [N_MOD-1:0]  idle_req,
    output logic [N_FCLK-1:0] fclk_en,
    output dom_state_e        dom_state
);
    localparam logic [N_MOD-1:0]  SLAVE_MASK = ~IS_MASTER;
    localparam logic [N_FCLK-1:0] FCLK_RST   = FCLK_PERM | ~FCLK_OPT;

    logic [N_FCLK-1:0] sw_q;
    logic [N_FCLK-1:0] fclk_d;
    logic              on_d;

    assign sw_chg = |(sw_fclk_en ^ sw_q);
    assign on_d   = phase_clocks_on(phase_nxt);

    for (genvar i = 0; i < N_FCLK; i++) begin : g_fclk
        if (FCLK_PERM[i]) begin : g_perm
            assign fclk_d[i] = 1'b1;
        end else if (FCLK_OPT[i]) begin : g_opt
            assign fclk_d[i] = on_d & sw_fclk_en[i];
        end else begin : g_mand
            assign fclk_d[i] = on_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q      <= '0;
            iclk_en   <= '1;
            idle_req  <= '0;
            fclk_en   <= FCLK_RST;
            dom_state <= DOM_ACTIVE;
        end else begin
            sw_q      <= sw_fclk_en;
            iclk_en   <= {N_MOD{on_d}};
            idle_req  <= phase_req_on(phase_nxt) ? SLAVE_MASK : '0;
            fclk_en   <= fclk_d;
            dom_state <= phase_to_dom(phase_nxt);
        end
    end
endmodule

// File: rtl/clkdom_gate_mgr.sv
module clkdom_gate_mgr #(
    parameter int unsigned N_MOD  = 4,
    parameter int unsigned N_FCLK = 4,
    parameter logic [N_MOD-1:0]  IS_MASTER = 4'b0011,
    parameter logic [N_FCLK-1:0] FCLK_OPT  = 4'b0110,
    parameter logic [N_FCLK-1:0] FCLK_PERM = 4'b1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wake_req,
    input  logic              auto_gate_en,
    input  logic [N_FCLK-1:0] sw_fclk_en,
    input  logic [N_MOD-1:0]  mst_standby,
    input  logic [N_MOD-1:0]  slv_idle_ack,
    output logic [N_MOD-1:0]  slv_idle_req,
    output logic [N_MOD-1:0]  iclk_en,
    output logic [N_FCLK-1:0] fclk_en,
    output logic [1:0]        dom_state
);
    import cgm_pkg::*;

    hs_sum_t    hs;
    phase_e     phase_nxt;
    logic       sw_chg;
    dom_state_e dom_q;

    cgm_hs_agg #(
        .N_MOD(N_MOD), .IS_MASTER(IS_MASTER)
    ) u_hs (
        .mst_standby(mst_standby),
        .slv_idle_ack(slv_idle_ack),
        .hs(hs)
    );

    cgm_phase_fsm u_fsm (
        .clk(clk),
        .rst(rst),
        .hs(hs),
        .wake_req(wake_req),
        .auto_gate_en(auto_gate_en),
        .sw_chg(sw_chg),
        .phase_nxt(phase_nxt)
    );

    cgm_enable_regs #(
        .N_MOD(N_MOD), .N_FCLK(N_FCLK), .IS_MASTER(IS_MASTER),
        .FCLK_OPT(FCLK_OPT), .FCLK_PERM(FCLK_PERM)
    ) u_en (
        .clk(clk),
        .rst(rst),
        .phase_nxt(phase_nxt),
        .sw_fclk_en(sw_fclk_en),
        .sw_chg(sw_chg),
        .iclk_en(iclk_en),
        .idle_req(slv_idle_req),
        .fclk_en(fclk_en),
        .dom_state(dom_q)
    );

    assign dom_state = dom_q;
endmodule

// File: rtl/cgm_checker.sv
module cgm_checker #(
    parameter int unsigned N_MOD  = 4,
    parameter int unsigned N_FCLK = 4,
    parameter logic [N_MOD-1:0]  IS_MASTER = 4'b0011,
    parameter logic [N_FCLK-1:0] FCLK_OPT  = 4'b0110,
    parameter logic [N_FCLK-1:0] FCLK_PERM = 4'b1000
) (
    input logic              clk,
    input logic              rst,
    input logic [N_MOD-1:0]  slv_idle_ack,
    input logic [N_MOD-1:0]  slv_idle_req,
    input logic [N_MOD-1:0]  iclk_en,
    input logic [N_FCLK-1:0] fclk_en,
    input logic [1:0]        dom_state
);
    localparam logic [N_FCLK-1:0] MAND = ~(FCLK_OPT | FCLK_PERM);

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        dom_state != 2'b11); // R1

    AST_NO_SKIP_GATE: assert property (@(posedge clk) disable iff (rst)
        $past(dom_state) == 2'b00 |-> dom_state != 2'b10); // R2

    AST_GATE_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(iclk_en[0]) |-> $past(&(slv_idle_ack | IS_MASTER))); // R3

    AST_ICLK_JOINT: assert property (@(posedge clk) disable iff (rst)
        (iclk_en == '0) || (iclk_en == '1)); // R5

    AST_ICLK_ON_AWAKE: assert property (@(posedge clk) disable iff (rst)
        dom_state != 2'b10 |-> iclk_en == '1); // R5

    AST_MAND_ON: assert property (@(posedge clk) disable iff (rst)
        iclk_en[0] |-> (fclk_en & MAND) == MAND); // R6

    AST_PERM_ON: assert property (@(posedge clk) disable iff (rst)
        (fclk_en & FCLK_PERM) == FCLK_PERM); // R8

    AST_REQ_TARGETS_ONLY: assert property (@(posedge clk) disable iff (rst)
        (slv_idle_req & IS_MASTER) == '0); // R9

    AST_WAKE_TO_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        ($past(dom_state) == 2'b10 && dom_state != 2'b10) |-> dom_state == 2'b00); // R10
endmodule

bind clkdom_gate_mgr cgm_checker #(
    .N_MOD(N_MOD), .N_FCLK(N_FCLK), .IS_MASTER(IS_MASTER),
    .FCLK_OPT(FCLK_OPT), .FCLK_PERM(FCLK_PERM)
) u_chk (
    .clk(clk),
    .rst(rst),
    .slv_idle_ack(slv_idle_ack),
    .slv_idle_req(slv_idle_req),
    .iclk_en(iclk_en),
    .fclk_en(fclk_en),
    .dom_state(dom_state)
);

// File: tb/clkdom_gate_mgr_tb.sv
module clkdom_gate_mgr_tb;
    localparam int N_MOD  = 4;
    localparam int N_FCLK = 4;
    localparam logic [3:0] IS_MASTER = 4'b0011;
    localparam logic [3:0] FCLK_OPT  = 4'b0110;
    localparam logic [3:0] FCLK_PERM = 4'b1000;
    localparam logic [3:0] TGT = ~IS_MASTER;

    localparam int M_RUN = 0, M_IREQ = 1, M_GATED = 2, M_WCLK = 3, M_WACK = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wake_req = 1'b0;
    logic auto_gate_en = 1'b0;
    logic [3:0] sw_fclk_en = '0;
    logic [3:0] mst_standby = '0;
    logic [3:0] slv_idle_ack = '0;
    logic [3:0] slv_idle_req;
    logic [3:0] iclk_en;
    logic [3:0] fclk_en;
    logic [1:0] dom_state;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_ph;
    logic [3:0] m_swq;
    logic [1:0] e_state;
    logic [3:0] e_iclk, e_fclk, e_req;

    always #2 clk = ~clk;

    clkdom_gate_mgr #(
        .N_MOD(N_MOD), .N_FCLK(N_FCLK), .IS_MASTER(IS_MASTER),
        .FCLK_OPT(FCLK_OPT), .FCLK_PERM(FCLK_PERM)
    ) u_dut (
        .clk(clk), .rst(rst), .wake_req(wake_req), .auto_gate_en(auto_gate_en),
        .sw_fclk_en(sw_fclk_en), .mst_standby(mst_standby), .slv_idle_ack(slv_idle_ack),
        .slv_idle_req(slv_idle_req), .iclk_en(iclk_en), .fclk_en(fclk_en),
        .dom_state(dom_state)
    );

    function automatic int next_ph(int ph, logic wk, logic au, logic chg,
                                   logic [3:0] stby, logic [3:0] ack);
        logic awake, all_ack, no_ack;
        awake   = wk | chg | ((stby & IS_MASTER) != IS_MASTER) | ~au;
        all_ack = (ack & TGT) == TGT;
        no_ack  = (ack & TGT) == '0;
        case (ph)
            M_RUN:   return awake ? M_RUN : M_IREQ;
            M_IREQ:  return awake ? M_RUN : (all_ack ? M_GATED : M_IREQ);
            M_GATED: return awake ? M_WCLK : M_GATED;
            M_WCLK:  return M_WACK;
            default: return no_ack ? M_RUN : M_WACK;
        endcase
    endfunction

    function automatic logic [3:0] exp_fclk(int ph, logic [3:0] sw);
        logic on;
        on = (ph != M_GATED);
        return FCLK_PERM | ({4{on}} & ~FCLK_OPT) | ({4{on}} & FCLK_OPT & sw);
    endfunction

    task automatic set_expect();
        e_state = (m_ph == M_RUN) ? 2'b00 : (m_ph == M_IREQ) ? 2'b01 : 2'b10;
        e_iclk  = (m_ph == M_GATED) ? 4'b0000 : 4'b1111;
        e_req   = (m_ph == M_IREQ || m_ph == M_GATED || m_ph == M_WCLK) ? TGT : 4'b0000;
    endtask

    task automatic model_step();
        if (rst) begin
            m_ph   = M_RUN;
            m_swq  = '0;
            e_fclk = FCLK_PERM | ~FCLK_OPT;
        end else begin
            m_ph   = next_ph(m_ph, wake_req, auto_gate_en, sw_fclk_en != m_swq,
                             mst_standby, slv_idle_ack);
            e_fclk = exp_fclk(m_ph, sw_fclk_en);
            m_swq  = sw_fclk_en;
        end
        set_expect();
    endtask

    task automatic chk(bit ok, string tag, logic [3:0] act, logic [3:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(dom_state == e_state, "R1 R2 R3 R4 R10 state", {2'b0, dom_state}, {2'b0, e_state});
        chk(iclk_en == e_iclk, "R5 iclk", iclk_en, e_iclk);
        chk((fclk_en & ~(FCLK_OPT | FCLK_PERM)) == (e_fclk & ~(FCLK_OPT | FCLK_PERM)),
            "R6 mandatory fclk", fclk_en, e_fclk);
        chk((fclk_en & FCLK_OPT) == (e_fclk & FCLK_OPT), "R7 optional fclk", fclk_en, e_fclk);
        chk((fclk_en & FCLK_PERM) == FCLK_PERM, "R8 permanent fclk", fclk_en, e_fclk);
        chk(slv_idle_req == e_req, "R9 idle req", slv_idle_req, e_req);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        check_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        // R11: reset values
        rst = 1'b1;
        tick();
        tick();
        chk(dom_state == 2'b00 && iclk_en == 4'b1111 && slv_idle_req == 4'b0000,
            "R11 reset state", {2'b0, dom_state}, 4'h0);
        chk(fclk_en == 4'b1001, "R11 reset fclk", fclk_en, 4'b1001);
        rst = 1'b0;
        auto_gate_en = 1'b1;
        mst_standby  = 4'b0011;
        tick();
        chk(dom_state == 2'b01 && slv_idle_req == TGT, "R2 enter idle transition",
            {2'b0, dom_state}, 4'h1);
        tick();
        tick();
        // R12: acknowledge on initiator bits must not complete the transition
        slv_idle_ack = 4'b0011;
        tick();
        tick();
        chk(dom_state == 2'b01 && iclk_en == 4'b1111, "R12 initiator ack ignored",
            {2'b0, dom_state}, 4'h1);
        slv_idle_ack = 4'b1100;
        tick();
        chk(dom_state == 2'b10 && iclk_en == 4'b0000 && fclk_en == 4'b1000,
            "R3 gated", iclk_en, 4'b0000);
        tick();
        wake_req = 1'b1;
        tick();
        chk(iclk_en == 4'b1111 && slv_idle_req == TGT && dom_state == 2'b10,
            "R10 clocks first", slv_idle_req, TGT);
        wake_req = 1'b0;
        auto_gate_en = 1'b0;
        tick();
        chk(slv_idle_req == 4'b0000 && dom_state == 2'b10, "R10 request dropped",
            slv_idle_req, 4'b0000);
        tick();
        chk(dom_state == 2'b10, "R10 waits for ack release", {2'b0, dom_state}, 4'h2);
        slv_idle_ack = 4'b0000;
        tick();
        chk(dom_state == 2'b00, "R10 active after release", {2'b0, dom_state}, 4'h0);
        // R7: optional clock follows software
        sw_fclk_en = 4'b0010;
        tick();
        chk(fclk_en == 4'b1011, "R7 optional on", fclk_en, 4'b1011);
        // R4: abort and completion on the same edge; abort wins
        auto_gate_en = 1'b1;
        tick();
        tick();
        chk(dom_state == 2'b01, "R2 re-enter idle transition", {2'b0, dom_state}, 4'h1);
        slv_idle_ack = 4'b1100;
        mst_standby  = 4'b0001;
        tick();
        chk(dom_state == 2'b00 && slv_idle_req == 4'b0000 && iclk_en == 4'b1111,
            "R4 abort beats completion", {2'b0, dom_state}, 4'h0);
        slv_idle_ack = 4'b0000;
        mst_standby  = 4'b1111; // R12: target standby bits carry no meaning
        tick();
        tick();
        // random phase
        for (int n = 0; n < 4000; n++) begin
            wake_req     = ($urandom % 16) == 0;
            auto_gate_en = ($urandom % 16) != 0;
            if (($urandom % 32) == 0) sw_fclk_en = 4'($urandom);
            mst_standby  = {2'($urandom), ($urandom % 8) != 0, ($urandom % 8) != 0};
            for (int b = 0; b < 4; b++)
                slv_idle_ack[b] = (($urandom % 4) != 0) ? slv_idle_req[b] : 1'($urandom);
            tick();
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
    end
endmodule